// File: doc/BRIEF.md
# Minimal 16-bit I/O processor core

This block is a compact sequencer for polled input/output work. It steps through a program of 16-bit words held in an on-chip ROM, and the ROM image is given as a parameter. Every instruction takes exactly four clocks: fetch the word, read the operand register, execute, then commit. The datapath is 8 bits wide. It has eight writable registers and a few constant read-only registers. Immediate arithmetic and logic set a single zero flag, which then steers relative branches. Absolute jumps and nested subroutine calls use a small return stack.

The core reaches peripherals over an 8-bit address and 8-bit data bus. A read strobe and a write strobe each stay high for the last two clocks of the instruction. A read takes the peripheral's data at the end of its strobe.

Top module: `iop_core`

## Requirements
- R1: While reset is applied, both bus strobes stay low. After release, execution starts at program address 0, so the first bus activity is the strobe of the instruction stored there.
- R2: Each instruction takes exactly four clocks. A bus strobe is high for exactly two consecutive clocks, in the third and fourth clock of its instruction. For example, the write two instructions after a read rises 8 clocks after that read.
- R3: The word layout is opcode in bits 15..12, register number in bits 11..8, and immediate value in bits 7..0. The immediate opcodes are 0 add (mod 256), 2 load, 4 XOR, 8 AND and 9 OR, and each writes its result back to the named register.
- R4: Opcode 3 shifts or rotates the register by one place. Bit 7 selects left (0) or right (1). Bits 6..5 select logical (00), arithmetic (01, right keeps the sign bit, left equals logical) or rotate (10).
- R5: Registers 0..7 can be read and written. Register 9 reads 0x01, register 15 reads 0xFF, and registers 8 and 10..14 read 0x00. Writes to registers 8..15 are discarded.
- R6: The zero flag is updated by add, compare, XOR, AND, OR, shift and I/O read, and by nothing else. Compare (opcode 1) sets it from register minus immediate and leaves the register unchanged.
- R7: Opcode C branches when the flag is set and opcode D branches when it is clear. The target is the branch's own address plus bits 11..0 taken as a two's-complement offset, and it wraps modulo 4096. An untaken branch falls through to the next word.
- R8: Opcode E loads bits 11..0 into the program counter.
- R9: Opcode A pushes the address of the next word and jumps to bits 11..0. Opcode B pops the pushed address. Calls nest up to the stack depth parameter.
- R10: Opcodes 5 and F change no register, no flag and no bus signal, and execution continues at the next word.
- R11: Opcode 6 reads into the named register and opcode 7 writes that register's value. The bus address is bits 7..0 and stays stable while a strobe is high. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_addr | output | 8 | Peripheral address, taken from the instruction |
| io_wdata | output | 8 | Write data, taken from the named register |
| io_rdata | input | 8 | Read data, sampled at the clock edge that ends the read strobe |
| io_rd | output | 1 | Read strobe, two clocks wide |
| io_wr | output | 1 | Write strobe, two clocks wide |

## Verification
The bench reaches every result through the bus. A test program loads peripheral values, transforms them and writes them back, so each result appears at the write strobe two or more instructions (8 or more clocks) after the read that supplied its operand. Read data is placed on the bus at the falling edge where the read strobe is first seen high, which is one and a half clocks before the capturing edge. Write address and data are sampled at the falling edge where the write strobe is first seen high. Strobe width is measured in falling edges while the strobe is high. The spacing between the first read and the first write of each loop pass is compared against 8 clocks.

// File: rtl/iop_pkg.sv
package iop_pkg;

  localparam int PC_W   = 12;
  localparam int DATA_W = 8;
  localparam int WORD_W = 16;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_CMP  = 4'h1,
    OP_LDI  = 4'h2,
    OP_SHF  = 4'h3,
    OP_XOR  = 4'h4,
    OP_RSVA = 4'h5,
    OP_INP  = 4'h6,
    OP_OUTP = 4'h7,
    OP_AND  = 4'h8,
    OP_OR   = 4'h9,
    OP_CALL = 4'hA,
    OP_RET  = 4'hB,
    OP_BRZ  = 4'hC,
    OP_BRNZ = 4'hD,
    OP_JUMP = 4'hE,
    OP_RSVB = 4'hF
  } op_e;

  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_READ   = 2'd1,
    PH_EXEC   = 2'd2,
    PH_COMMIT = 2'd3
  } phase_e;

endpackage

// File: rtl/iop_seq.sv
module iop_seq
  import iop_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase
);

  phase_e phase_q, phase_d;

  always_comb begin
    unique case (phase_q)
      PH_FETCH:  phase_d = PH_READ;
      PH_READ:   phase_d = PH_EXEC;
      PH_EXEC:   phase_d = PH_COMMIT;
      default:   phase_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_FETCH;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_COMMIT) |=> (phase_q == PH_FETCH)); // R2

endmodule

// File: rtl/iop_regfile.sv
module iop_regfile #(
  parameter int NUM_RW = 8,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_sel,
  input  logic [DW-1:0] wr_data
);

  localparam int IW = (NUM_RW > 1) ? $clog2(NUM_RW) : 1;

  logic [DW-1:0] store_q [NUM_RW];

  for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_sel == 4'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   store_q[g] <= '0;
      else if (hit) store_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_sel) < NUM_RW)  rd_data = store_q[rd_sel[IW-1:0]];
    else if (rd_sel == 4'h9)    rd_data = DW'(1);
    else if (rd_sel == 4'hF)    rd_data = '1;
  end

endmodule

// File: rtl/iop_alu.sv
module iop_alu
  import iop_pkg::*;
(
  input  op_e              op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] res,
  output logic              wr_reg,
  output logic              upd_z
);

  logic [DATA_W-1:0] shf;
  logic              go_right;
  logic [1:0]        kind;

  assign go_right = imm[7];
  assign kind     = imm[6:5];

  always_comb begin
    if (!go_right) begin
      if (kind == 2'b10) shf = {a[DATA_W-2:0], a[DATA_W-1]};
      else               shf = {a[DATA_W-2:0], 1'b0};
    end else begin
      unique case (kind)
        2'b01:   shf = {a[DATA_W-1], a[DATA_W-1:1]};
        2'b10:   shf = {a[0], a[DATA_W-1:1]};
        default: shf = {1'b0, a[DATA_W-1:1]};
      endcase
    end
  end

  always_comb begin
    res    = a;
    wr_reg = 1'b0;
    upd_z  = 1'b0;
    unique case (op)
      OP_ADD: begin res = a + imm; wr_reg = 1'b1; upd_z = 1'b1; end
      OP_CMP: begin res = a - imm; upd_z = 1'b1; end
      OP_LDI: begin res = imm;     wr_reg = 1'b1; end
      OP_SHF: begin res = shf;     wr_reg = 1'b1; upd_z = 1'b1; end
      OP_XOR: begin res = a ^ imm; wr_reg = 1'b1; upd_z = 1'b1; end
      OP_AND: begin res = a & imm; wr_reg = 1'b1; upd_z = 1'b1; end
      OP_OR:  begin res = a | imm; wr_reg = 1'b1; upd_z = 1'b1; end
      default: ;
    endcase
  end

endmodule

// File: rtl/iop_pcunit.sv
module iop_pcunit
  import iop_pkg::*;
#(
  parameter int STACK_DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  op_e             op,
  input  logic [PC_W-1:0] tgt,
  input  logic            zf,
  output logic [PC_W-1:0] pc
);

  logic [PC_W-1:0] pc_q, pc_d, pc_inc, ret_top;
  logic            push, pop;

  assign pc_inc = pc_q + PC_W'(1);
  assign push   = commit && (op == OP_CALL);
  assign pop    = commit && (op == OP_RET);

  always_comb begin
    unique case (op)
      OP_JUMP: pc_d = tgt;
      OP_CALL: pc_d = tgt;
      OP_RET:  pc_d = ret_top;
      OP_BRZ:  pc_d = zf  ? pc_q + tgt : pc_inc;
      OP_BRNZ: pc_d = !zf ? pc_q + tgt : pc_inc;
      default: pc_d = pc_inc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= '0;
    else if (commit) pc_q <= pc_d;
  end

  if (STACK_DEPTH <= 1) begin : g_single
    logic [PC_W-1:0] link_q;
    always_ff @(posedge clk) begin
      if (push) link_q <= pc_inc;
    end
    assign ret_top = link_q;
    logic unused_pop;
    assign unused_pop = pop;
  end else begin : g_deep
    localparam int SP_W = $clog2(STACK_DEPTH);
    logic [PC_W-1:0] mem_q [STACK_DEPTH];
    logic [SP_W-1:0] sp_q, sp_d, sp_dec;
    assign sp_dec = sp_q - SP_W'(1);
    always_comb begin
      sp_d = sp_q;
      if (push)     sp_d = sp_q + SP_W'(1);
      else if (pop) sp_d = sp_dec;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sp_q <= '0;
      else        sp_q <= sp_d;
    end
    always_ff @(posedge clk) begin
      if (push) mem_q[sp_q] <= pc_inc;
    end
    assign ret_top = mem_q[sp_dec];
  end

  assign pc = pc_q;

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(pc_q)); // R2
  AST_JUMP_ABS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && op == OP_JUMP) |=> (pc_q == $past(tgt))); // R8
  AST_RSV_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (op == OP_RSVA || op == OP_RSVB)) |=> (pc_q == $past(pc_q) + PC_W'(1))); // R10

endmodule

// File: rtl/iop_core.sv
module iop_core
  import iop_pkg::*;
#(
  parameter int                      PROG_WORDS  = 64,
  parameter logic [16*PROG_WORDS-1:0] PROG_IMAGE = '0,
  parameter int                      STACK_DEPTH = 16,
  parameter int                      NUM_RW      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [7:0] io_addr,
  output logic [7:0] io_wdata,
  input  logic [7:0] io_rdata,
  output logic       io_rd,
  output logic       io_wr
);

  localparam logic [WORD_W-1:0] FILL_WORD = 16'hF000;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  phase_e            phase;
  logic [PC_W-1:0]   pc;
  logic [WORD_W-1:0] ir_q, ir_d, rom_word;
  logic [DATA_W-1:0] opnd_q, opnd_d, res_q, res_d, rf_rd, alu_res, wb_data;
  logic              zf_q, zf_d;
  logic              ir_en, opnd_en, res_en, commit;
  logic              alu_wr, alu_upd, rf_we, is_inp, is_outp;
  op_e               op;

  iop_seq u_seq (.clk(clk), .rst_n(rst_sync_q), .phase(phase));

  always_comb begin
    rom_word = FILL_WORD;
    if (int'(pc) < PROG_WORDS) rom_word = PROG_IMAGE[16*int'(pc) +: 16];
  end

  assign ir_en   = (phase == PH_FETCH);
  assign opnd_en = (phase == PH_READ);
  assign res_en  = (phase == PH_EXEC);
  assign commit  = (phase == PH_COMMIT);

  assign op      = op_e'(ir_q[15:12]);
  assign is_inp  = (op == OP_INP);
  assign is_outp = (op == OP_OUTP);

  assign ir_d   = ir_en   ? rom_word : ir_q;
  assign opnd_d = opnd_en ? rf_rd    : opnd_q;
  assign res_d  = res_en  ? alu_res  : res_q;

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      ir_q   <= '0;
      opnd_q <= '0;
      res_q  <= '0;
      zf_q   <= 1'b0;
    end else begin
      ir_q   <= ir_d;
      opnd_q <= opnd_d;
      res_q  <= res_d;
      zf_q   <= zf_d;
    end
  end

  iop_alu u_alu (
    .op(op), .a(opnd_q), .imm(ir_q[7:0]),
    .res(alu_res), .wr_reg(alu_wr), .upd_z(alu_upd)
  );

  always_comb begin
    zf_d = zf_q;
    if (commit && is_inp)       zf_d = (io_rdata == '0);
    else if (commit && alu_upd) zf_d = (res_q == '0);
  end

  assign rf_we   = commit && (alu_wr || is_inp);
  assign wb_data = is_inp ? io_rdata : res_q;

  iop_regfile #(.NUM_RW(NUM_RW), .DW(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_sync_q),
    .rd_sel(ir_q[11:8]), .rd_data(rf_rd),
    .wr_en(rf_we), .wr_sel(ir_q[11:8]), .wr_data(wb_data)
  );

  iop_pcunit #(.STACK_DEPTH(STACK_DEPTH)) u_pc (
    .clk(clk), .rst_n(rst_sync_q), .commit(commit), .op(op),
    .tgt(ir_q[11:0]), .zf(zf_q), .pc(pc)
  );

  assign io_addr  = ir_q[7:0];
  assign io_wdata = opnd_q;
  assign io_rd    = is_inp  && (phase == PH_EXEC || phase == PH_COMMIT);
  assign io_wr    = is_outp && (phase == PH_EXEC || phase == PH_COMMIT);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !(io_rd && io_wr)); // R11
  AST_WR_TWO: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(io_wr) |=> io_wr); // R2
  AST_WR_END: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (io_wr && $past(io_wr)) |=> !io_wr); // R2
  AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (io_rd && $past(io_rd)) |-> $stable(io_addr)); // R11
  AST_WR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (io_wr && $past(io_wr)) |-> $stable(io_wdata)); // R11

endmodule

// File: tb/iop_core_bench.sv
module iop_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NWORDS     = 64;
  localparam int NCODE      = 51;
  localparam int NWR        = 19;
  localparam int ITERS      = 30;

  localparam logic [15:0] CODE [NCODE] = '{
    16'h6010, 16'h0035, 16'h7020, 16'h5012, 16'hF0FF, 16'h702D,
    16'h6110, 16'h415A, 16'h7121,
    16'h6210, 16'h82F0, 16'h7222, 16'h920F, 16'h7223,
    16'h6310, 16'h3300, 16'h7324, 16'h6310, 16'h33A0, 16'h7325,
    16'h6310, 16'h33C0, 16'h7326, 16'h6310, 16'h3340, 16'h7327,
    16'h6310, 16'h3380, 16'h7328,
    16'h6410, 16'h1400, 16'hC003, 16'h792A, 16'hE023, 16'h7F2A, 16'h742B,
    16'h2855, 16'h782E,
    16'h2603, 16'h06FF, 16'h762F, 16'hDFFE,
    16'hA02D, 16'h7F31, 16'hE000,
    16'hA030, 16'h7930, 16'hB000,
    16'h2577, 16'h752C, 16'hB000
  };

  localparam logic [7:0] WSEQ [NWR] = '{
    8'h20, 8'h2D, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26, 8'h27, 8'h28,
    8'h2A, 8'h2B, 8'h2E, 8'h2F, 8'h2F, 8'h2F, 8'h2C, 8'h30, 8'h31
  };

  function automatic logic [16*NWORDS-1:0] build_image();
    logic [16*NWORDS-1:0] img;
    img = '0;
    for (int i = 0; i < NWORDS; i++)
      img[16*i +: 16] = (i < NCODE) ? CODE[i] : 16'hF000;
    return img;
  endfunction

  localparam logic [16*NWORDS-1:0] IMAGE = build_image();

  logic       clk, rst_n;
  logic [7:0] io_addr, io_wdata, io_rdata;
  logic       io_rd, io_wr;

  iop_core #(.PROG_WORDS(NWORDS), .PROG_IMAGE(IMAGE), .STACK_DEPTH(16)) u_iop_core (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_rd(io_rd), .io_wr(io_wr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, iter = 0, rd_idx = 0, wr_idx = 0, wr_len = 0, t_first = 0;
  bit live = 0, first_seen = 0, rd_prev = 0, wr_prev = 0;
  logic [7:0] slot [9];

  task automatic chk(input bit ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] pick();
    logic [7:0] corner [6] = '{8'h00, 8'h80, 8'hFF, 8'h01, 8'h7F, 8'hCA};
    if ($urandom % 4 == 0) return corner[$urandom % 6];
    return 8'($urandom);
  endfunction

  function automatic string req_of(input logic [7:0] a);
    case (a)
      8'h24, 8'h25, 8'h26, 8'h27, 8'h28: return "R4";
      8'h2E, 8'h30, 8'h31:               return "R5";
      8'h2A, 8'h2B:                      return "R6";
      8'h2F:                             return "R7";
      8'h2C:                             return "R9";
      8'h2D:                             return "R10";
      default:                           return "R3";
    endcase
  endfunction

  function automatic logic [7:0] exp_data(input logic [7:0] a, input int idx);
    case (a)
      8'h20, 8'h2D: return slot[0] + 8'h35;
      8'h21: return slot[1] ^ 8'h5A;
      8'h22: return slot[2] & 8'hF0;
      8'h23: return (slot[2] & 8'hF0) | 8'h0F;
      8'h24: return {slot[3][6:0], 1'b0};
      8'h25: return {slot[4][7], slot[4][7:1]};
      8'h26: return {slot[5][0], slot[5][7:1]};
      8'h27: return {slot[6][6:0], slot[6][7]};
      8'h28: return {1'b0, slot[7][7:1]};
      8'h2A: return (slot[8] == 8'h00) ? 8'hFF : 8'h01;
      8'h2B: return slot[8];
      8'h2E: return 8'h00;
      8'h2F: return 8'(15 - idx);
      8'h2C: return 8'h77;
      8'h30: return 8'h01;
      8'h31: return 8'hFF;
      default: return 8'hXX;
    endcase
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (live) begin
      if (io_rd && !rd_prev) begin
        logic [7:0] v;
        if (!first_seen) begin
          chk(1'b1, "R1", 8'h00, 8'h00);
          first_seen = 1;
        end
        chk(io_addr == 8'h10, "R11", io_addr, 8'h10);
        chk(!io_wr, "R11", 8'(io_wr), 8'h00);
        v = pick();
        io_rdata = v;
        slot[rd_idx] = v;
        if (rd_idx == 0) t_first = cyc;
        rd_idx = (rd_idx == 8) ? 0 : rd_idx + 1;
      end
      if (io_wr && !wr_prev) begin
        logic [7:0] ea;
        if (!first_seen) begin
          chk(1'b0, "R1", 8'h01, 8'h00);
          first_seen = 1;
        end
        ea = WSEQ[wr_idx];
        // write order exercises branches, jumps and calls (R7 R8 R9)
        chk(io_addr == ea, "R8", io_addr, ea);
        chk(io_wdata === exp_data(ea, wr_idx), req_of(ea), io_wdata, exp_data(ea, wr_idx));
        if (wr_idx == 0) chk(cyc - t_first == 8, "R2", 8'(cyc - t_first), 8'd8);
        if (wr_idx == NWR - 1) begin
          wr_idx = 0;
          iter++;
        end else wr_idx++;
      end
      if (io_wr) wr_len++;
      if (!io_wr && wr_prev) begin
        chk(wr_len == 2, "R2", 8'(wr_len), 8'd2);
        wr_len = 0;
      end
      rd_prev = io_rd;
      wr_prev = io_wr;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n    = 1'b0;
    io_rdata = 8'h00;
    repeat (4) begin
      @(negedge clk);
      chk(!io_rd && !io_wr, "R1", {6'd0, io_rd, io_wr}, 8'h00);
    end
    rst_n = 1'b1;
    live  = 1;
    while (iter < ITERS && cyc < 150000) @(negedge clk);
    if (iter < ITERS) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: R2 actual=%0d expected=%0d loop passes", iter, ITERS);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule